// File: doc/BRIEF.md
# Stepped Post-Divider with Gradual Power-Down

This block sits between a fast clock and a clock output pin. It divides the fast clock by a programmed ratio of 1, 2, 4 or 8, and the output always has a 50% duty cycle. The output is built from registers, so the ratio-1 output runs at half the fast-clock rate. At any ratio R, the output period is 2·R fast-clock cycles.

A power-down request adds an extra division on top of the programmed ratio, and this extra division reaches 16. It gets there in stages, so the output frequency slides down instead of jumping. Each stage is paced by a rising edge of a slow reference clock. That reference is brought into the fast-clock domain before use. When the request is released, the extra division steps back to 1 in four stages. A change of ratio never takes effect in the middle of a pulse. A settled flag reports that the staging has reached the target for the current request.

Top module: `pd_step_divider`

## Requirements
- R1: The 2-bit ratio code selects the division: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. With no power-down, the output period is 2, 4, 8 or 16 fast-clock cycles.
- R2: At every ratio, the output stays high for exactly as many fast-clock cycles as the low phase that precedes it.
- R3: Once power-down has fully staged in, the output period is 16 times the programmed period.
- R4: While power-down is requested, each reference rising edge raises the extra division by one stage, through ×2, ×4, ×8 and ×16, and it never goes past ×16.
- R5: After the request is released, each reference rising edge lowers the extra division by one stage, through ×8, ×4, ×2 and ×1.
- R6: A new ratio is loaded only when the output falls. The next low phase and the high phase after it both use the new ratio, so no shortened pulse is ever produced.
- R7: A change of the ratio code while running is applied at the next falling edge of the output, and the half-period count restarts from zero there.
- R8: The reference input passes through two synchronizing flops and an edge detector. A stage change takes effect at the third fast-clock edge after the reference is first sampled high.
- R9: The settled flag is high when the extra division is ×1 with no request, or ×16 with a request. Otherwise it is low.
- R10: A synchronous active-low reset drives the output low, clears the extra division to ×1, loads the current ratio code, and restarts the half-period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock that paces power-down stages (asynchronous) |
| ratio_code | input | 2 | Programmed ratio: 00=/1, 01=/2, 10=/4, 11=/8 |
| pd_req | input | 1 | Power-down request, high to stage in the extra divide by 16 |
| clk_out | output | 1 | Divided output clock, 50% duty |
| settled | output | 1 | Extra division has reached the target for the current request |

## Verification
A rising edge of the reference changes the stage three fast-clock edges later. The settled flag follows in that same cycle. The output period changes only from the next falling edge of the output. A ratio-code change likewise shows up first in the low phase that starts at the next fall.

All inputs are driven 2 ns after a rising edge. A behavioural model updates its state on each rising edge, and the design is compared with it at every falling edge, so every latency above is checked at its exact cycle. Separate directed checks measure whole output periods after settling, and compare each high phase with the low phase before it.

// File: rtl/pd_step_pkg.sv
// Shared sizing for the stepped post-divider.
// Assumes: ratio exponent 0..3 plus up to PD_STEPS extra stages.
package pd_step_pkg;
    parameter int CODE_W   = 2;
    parameter int PD_STEPS = 4;
    localparam int LVL_W   = $clog2(PD_STEPS + 1);
    localparam int EXP_W   = $clog2((2 ** CODE_W) + PD_STEPS);
    localparam int CNT_W   = (2 ** EXP_W) - 1;
    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pd_ref_sync.sv
// Brings the slow reference clock into the fast domain and emits a
// one-cycle pulse for each rising edge.
// Assumes: each reference level is held for at least three fast cycles.
module pd_ref_sync (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic ref_clk,
    output logic tick
);
    logic [2:0] sh;

    // Two synchronizing flops followed by one history flop.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], ref_clk};
    end

    assign tick = sh[1] & ~sh[2];

    // A tick never lasts longer than one cycle.
    assert_tick_single_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pd_stage_ctrl.sv
// Holds the power-down stage (0 = x1 .. PD_STEPS = x16). It moves one
// stage per reference tick toward the target and reports when it is settled.
// Assumes: tick is a single-cycle pulse in the fast domain.
module pd_stage_ctrl
    import pd_step_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    input  logic tick,
    input  logic pd_req,
    output lvl_t lvl,
    output logic settled
);
    localparam lvl_t LVL_TOP = lvl_t'(PD_STEPS);

    // Step one stage toward the target on each tick.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)                          lvl <= '0;
        else if (tick && pd_req && lvl != LVL_TOP) lvl <= lvl + 1'b1;
        else if (tick && !pd_req && lvl != '0)     lvl <= lvl - 1'b1;
    end

    assign settled = (lvl == (pd_req ? LVL_TOP : lvl_t'(0)));

    // Stage never exceeds the top.
    assert_lvl_top_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        lvl <= LVL_TOP);
    // Without a tick the stage holds.
    assert_paced_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !tick |=> $stable(lvl));
    // Any move is exactly one stage.
    assert_one_step_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(lvl) |-> ((lvl - $past(lvl)) == lvl_t'(1) || ($past(lvl) - lvl) == lvl_t'(1)));
endmodule

// File: rtl/pd_div_core.sv
// Divides the fast clock by 2**exponent per half period. A new exponent
// is loaded only when the output falls, so both halves of a period match.
// Assumes: exponent target is stable or changes slowly relative to output.
module pd_div_core
    import pd_step_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    input  exp_t exp_tgt,
    output logic clk_out
);
    exp_t             exp_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last_cnt;
    logic             at_end;

    // Length of the current half period, less one.
    always_comb begin
        span     = (CNT_W+1)'(1) << exp_act;
        last_cnt = CNT_W'(span - (CNT_W+1)'(1));
        at_end   = (cnt == last_cnt);
    end

    // Half-period counter, output toggle, and exponent load at the falling edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            cnt     <= '0;
            clk_out <= 1'b0;
            exp_act <= exp_tgt;
        end else if (at_end) begin
            cnt     <= '0;
            clk_out <= ~clk_out;
            if (clk_out) exp_act <= exp_tgt;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Counter stays inside the active half period.
    assert_cnt_range_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        cnt <= last_cnt);
    // The exponent never changes across a rising output edge.
    assert_rise_hold_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(clk_out) |-> $stable(exp_act));
    // The exponent only changes when the output has just fallen.
    assert_load_on_fall_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(exp_act) |-> $fell(clk_out));
endmodule

// File: rtl/pd_step_divider.sv
// Top: programmable post-divider (/1,/2,/4,/8) with a staged extra divide
// by 16 for power-down, paced by a reference clock.
// Assumes: clk_out at ratio 1 is half the fast-clock rate.
module pd_step_divider
    import pd_step_pkg::*;
(
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              pd_req,
    output logic              clk_out,
    output logic              settled
);
    logic tick;
    lvl_t lvl;
    exp_t exp_tgt;

    // Total exponent is the programmed ratio plus the power-down stage.
    always_comb exp_tgt = exp_t'(ratio_code) + exp_t'(lvl);

    pd_ref_sync u_sync (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .tick     (tick)
    );

    pd_stage_ctrl u_stage (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .tick     (tick),
        .pd_req   (pd_req),
        .lvl      (lvl),
        .settled  (settled)
    );

    pd_div_core u_div (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .exp_tgt  (exp_tgt),
        .clk_out  (clk_out)
    );

    // A settled power-down means the top stage is reached.
    assert_settled_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (settled && pd_req) |-> (lvl == lvl_t'(PD_STEPS)));
endmodule

// File: tb/sim_pd_step_divider.sv
module sim_pd_step_divider;
    logic       clk_fast = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic [1:0] ratio_code = 2'b00;
    logic       pd_req = 1'b0;
    logic       clk_out;
    logic       settled;

    integer n_chk = 0;
    integer n_bad = 0;
    bit     done = 0;
    bit     mon_on = 0;
    bit     ref_run = 0;

    always #4 clk_fast = ~clk_fast;

    pd_step_divider u0 (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .ref_clk    (ref_clk),
        .ratio_code (ratio_code),
        .pd_req     (pd_req),
        .clk_out    (clk_out),
        .settled    (settled)
    );

    // Behavioural reference model: reference history queue and integer state.
    integer rq[$];
    integer m_lvl, m_left, m_out, m_half;
    initial begin m_lvl = 0; m_left = 1; m_out = 0; m_half = 1; rq = '{0, 0, 0}; end

    always @(posedge clk_fast) begin
        integer rose;
        if (!rst_n) begin
            m_lvl = 0; m_out = 0; m_half = 1 << ratio_code; m_left = m_half;
            rq = '{0, 0, 0};
        end else begin
            rose = (rq[1] == 1 && rq[2] == 0);
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_out == 1) m_half = 1 << (ratio_code + m_lvl);
                m_out = 1 - m_out;
                m_left = m_half;
            end
            if (rose) begin
                if (pd_req && m_lvl < 4) m_lvl = m_lvl + 1;
                else if (!pd_req && m_lvl > 0) m_lvl = m_lvl - 1;
            end
            rq.push_front(ref_clk ? 1 : 0);
            void'(rq.pop_back());
        end
    end

    // Compare every cycle against the model (R1 R3 R4 R5 R7 R8 R9 R10).
    always @(negedge clk_fast) begin
        integer exp_set;
        if (!done) begin
            exp_set = (m_lvl == (pd_req ? 4 : 0));
            n_chk = n_chk + 1;
            if (clk_out !== m_out[0] || settled !== exp_set[0]) begin
                n_bad = n_bad + 1;
                $display("FAIL R4 R5 R7 R8 R9 R10 cycle compare: clk_out=%0b settled=%0b expected %0d %0d",
                         clk_out, settled, m_out, exp_set);
            end
        end
    end

    // Duty monitor: every high phase matches the preceding low phase (R2 R6).
    integer run_len = 0, low_len = 0, prev_v = 0;
    always @(negedge clk_fast) begin
        if (mon_on && !done) begin
            if (clk_out == prev_v[0]) run_len = run_len + 1;
            else begin
                if (prev_v == 1) begin
                    n_chk = n_chk + 1;
                    if (run_len != low_len) begin
                        n_bad = n_bad + 1;
                        $display("FAIL R2 R6 high phase %0d expected %0d", run_len, low_len);
                    end
                end else low_len = run_len;
                run_len = 1;
                prev_v = clk_out ? 1 : 0;
            end
        end
    end

    // Reference clock: toggles every 37 fast cycles while enabled.
    initial begin
        forever begin
            repeat (37) @(posedge clk_fast);
            #2;
            if (ref_run) ref_clk = ~ref_clk;
        end
    end

    task automatic tick_n(input integer n);
        repeat (n) @(posedge clk_fast);
        #2;
    endtask

    // Measure one full output period in fast cycles.
    task automatic chk_period(input integer exp_p, input string tag);
        integer cyc = 0;
        @(negedge clk_fast);
        while (clk_out !== 1'b0) @(negedge clk_fast);
        while (clk_out !== 1'b1) @(negedge clk_fast);
        @(negedge clk_fast); cyc = 1;
        while (clk_out !== 1'b0) begin @(negedge clk_fast); cyc++; end
        while (clk_out !== 1'b1) begin @(negedge clk_fast); cyc++; end
        n_chk = n_chk + 1;
        if (cyc != exp_p) begin
            n_bad = n_bad + 1;
            $display("FAIL %s period %0d expected %0d", tag, cyc, exp_p);
        end
        @(posedge clk_fast); #2;
    endtask

    task automatic wait_settled;
        integer guard = 0;
        @(negedge clk_fast);
        while (settled !== 1'b1 && guard < 5000) begin @(negedge clk_fast); guard++; end
        @(posedge clk_fast); #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_fast);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick_n(4);
        // R10: reset state observed while reset is held
        n_chk = n_chk + 1;
        if (clk_out !== 1'b0 || settled !== 1'b1) begin
            n_bad = n_bad + 1;
            $display("FAIL R10 reset clk_out=%0b settled=%0b expected 0 1", clk_out, settled);
        end
        rst_n = 1'b1;
        mon_on = 1;
        for (int c = 0; c < 4; c++) begin
            ratio_code = 2'(c);
            tick_n(40);
            chk_period(2 << c, "R1");
            ref_run = 1;
            pd_req = 1'b1;
            tick_n(1);
            // R9: not settled just after the request
            n_chk = n_chk + 1;
            if (settled !== 1'b0) begin
                n_bad = n_bad + 1;
                $display("FAIL R9 settled=%0b expected 0", settled);
            end
            wait_settled();
            tick_n(600);
            chk_period(2 << (c + 4), "R3");
            pd_req = 1'b0;
            wait_settled();
            tick_n(300);
            chk_period(2 << c, "R5");
            ref_run = 0;
        end
        // R7: ratio change inside a high phase, then inside a low phase
        ratio_code = 2'b01;
        @(negedge clk_fast);
        while (clk_out !== 1'b1) @(negedge clk_fast);
        @(posedge clk_fast); #2;
        ratio_code = 2'b11;
        tick_n(3);
        ratio_code = 2'b10;
        tick_n(100);
        chk_period(8, "R7");
        // R4 R6: release in the middle of staging and re-request
        ref_run = 1;
        pd_req = 1'b1;
        tick_n(120);
        pd_req = 1'b0;
        tick_n(80);
        pd_req = 1'b1;
        tick_n(400);
        pd_req = 1'b0;
        wait_settled();
        tick_n(200);
        finish_run();
    end
endmodule